// File: doc/BRIEF.md
# Direct-Mapped Loop Instruction Buffer

This block sits between an instruction fetch unit and main memory and keeps a small, software-invisible copy of recently fetched instruction words. It holds 32 entries. Each entry carries one 48-bit instruction, the upper 12 bits of the word address it was read from, and a valid flag. Every fetch address is split into a 5-bit index (the low bits) and a 12-bit tag (the high bits). The index selects one entry, and the tag is compared with the stored one before anything is sent to memory. A match returns the stored word on the next clock and leaves memory alone. A mismatch passes the request straight to the memory read port in the same cycle. The word that comes back is handed to the fetch unit in the cycle it arrives, and the buffer keeps a copy of it under the new tag at that moment.

Nothing is loaded ahead of use. Entries fill only as fetched words are consumed, so a straight-line loop that fits in 32 consecutive words runs from memory once and then entirely from the buffer. Longer loops lose hits as they wrap onto their own entries. Two plain control inputs keep the contents honest. A flush pulse empties the buffer. A store snoop removes the entry for a written address. A store to the address of an outstanding miss also stops that miss from being kept.

All data-carrying channels use valid/ready. A request is taken when `req_valid` and `req_ready` are both high. The requester must hold `req_valid` and `req_addr` steady until then. The response is held (`rsp_valid`, `rsp_data`, `rsp_hit` unchanged) while `rsp_ready` is low. The block holds `mem_req_valid` and `mem_req_addr` until `mem_req_ready`. Memory must hold `mem_rsp_valid` and `mem_rsp_data` until `mem_rsp_ready`, which follows `rsp_ready` while a miss is outstanding. Only one miss is in flight at a time.

Top module: `instr_loop_buf`

## Requirements
- R1: After reset, and in the cycle after a `flush` pulse, no entry is valid. At reset `rsp_valid` and `mem_req_valid` are low, and the next fetch of any address misses.
- R2: Address bits [4:0] are the index and bits [16:5] are the tag. A request whose indexed entry is valid with an equal tag is accepted without raising `mem_req_valid`. Its response appears in the next cycle with `rsp_hit`=1 and the stored word.
- R3: A request that misses raises `mem_req_valid` in the same cycle, with `mem_req_addr` equal to `req_addr`. It is accepted together with the memory request. The memory word is presented on `rsp_data` with `rsp_valid`=1 and `rsp_hit`=0 in the same cycle that `mem_rsp_valid` is high, which adds no cycle to a plain memory fetch.
- R4: When a miss response is taken, the word and its tag are written into the indexed entry. A later fetch of the same address hits.
- R5: A fetch whose index matches a valid entry but whose tag differs misses, and its fill replaces that entry. The replaced address then misses.
- R6: Fetching a run of L ≤ 32 consecutive addresses twice after a flush gives L misses on the first pass and L hits on the second.
- R7: For consecutive runs with 32 < L ≤ 64 fetched twice after a flush, the second pass gives exactly 64−L hits (24 for L=40, 16 for L=48).
- R8: A store snoop (`st_valid`, `st_addr`) clears the entry holding that exact address. A store whose tag differs from the entry's tag leaves the entry valid.
- R9: A flush or a matching store in the same cycle as a request forces that request to miss. A store to the address of the outstanding miss, in any cycle up to and including the one in which its response is taken, stops that word from being written into the buffer.
- R10: Back-pressure: a response held by low `rsp_ready` keeps its valid and data unchanged, and a memory request keeps its valid and address until accepted. With `rsp_ready` high, hits are accepted on consecutive cycles, so a 32-word all-hit run is accepted in 32 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Pulse that invalidates every entry |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | Fetch request accepted this cycle when valid is high |
| req_addr | input | 17 | Fetch word address |
| rsp_valid | output | 1 | Fetch response valid |
| rsp_ready | input | 1 | Fetch unit can take the response |
| rsp_data | output | 48 | Returned instruction word |
| rsp_hit | output | 1 | High when the response came from the buffer |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 17 | Memory read word address |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_ready | output | 1 | Block takes the memory read data |
| mem_rsp_data | input | 48 | Memory read data |
| st_valid | input | 1 | Store snoop valid |
| st_addr | input | 17 | Word address written by the store |

## Verification
Some properties are checked on every cycle. A held response or memory request must keep its payload stable. An accepted hit must produce a hit response on the next cycle. A flush must leave no valid entry. A fill must leave its entry valid under the new tag. A snooped store must remove a matching entry unless a fill to the same index overwrites it. The scenarios in the bench cover the rest: whether a given fetch hits after a particular history of fills, conflicts, stores and flushes, the exact hit counts of looped runs below and above 32 words, the suppression of a fill by a store during an outstanding miss, and one-per-cycle hit throughput. For these the bench compares every response against a model built from the requirements.

// File: rtl/lbuf_pkg.sv
package lbuf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIT  = 2'd1,
    ST_WAIT = 2'd2
  } lbuf_state_e;
endpackage

// File: rtl/lbuf_tag_array.sv
module lbuf_tag_array #(
  parameter int IDX_W = 5,
  parameter int TAG_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             inv_en,
  input  logic [IDX_W-1:0] inv_idx,
  input  logic [TAG_W-1:0] inv_tag
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0]            vld;
  logic [DEPTH-1:0][TAG_W-1:0] tags;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic             v_q;
    logic [TAG_W-1:0] t_q;
    // flush beats fill, fill beats a store snoop on the same entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        t_q <= '0;
      end else if (flush) begin
        v_q <= 1'b0;
      end else if (fill_en && fill_idx == IDX_W'(i)) begin
        v_q <= 1'b1;
        t_q <= fill_tag;
      end else if (inv_en && inv_idx == IDX_W'(i) && t_q == inv_tag) begin
        v_q <= 1'b0;
      end
    end
    assign vld[i]  = v_q;
    assign tags[i] = t_q;
  end

  assign lk_hit = vld[lk_idx] && (tags[lk_idx] == lk_tag);

  p_flush_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld == '0))
    else $error("flush left a valid entry");

  p_fill_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush) |=> (vld[$past(fill_idx)] && tags[$past(fill_idx)] == $past(fill_tag)))
    else $error("fill did not leave entry valid");

  p_store_inv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_en && !(fill_en && fill_idx == inv_idx))
      |=> !(vld[$past(inv_idx)] && tags[$past(inv_idx)] == $past(inv_tag)))
    else $error("store left matching entry valid");
endmodule

// File: rtl/lbuf_data_array.sv
module lbuf_data_array #(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 48
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) words[wr_idx] <= wr_data;
  end

  assign rd_data = words[rd_idx];
endmodule

// File: rtl/lbuf_ctrl.sv
module lbuf_ctrl
  import lbuf_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_hit,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic              lk_hit,
  input  logic [DATA_W-1:0] buf_data,
  output logic              fill_en,
  output logic [ADDR_W-1:0] fill_addr,
  output logic [DATA_W-1:0] fill_data
);
  lbuf_state_e       state;
  logic [ADDR_W-1:0] pend_addr;
  logic              kill_q;
  logic [DATA_W-1:0] hold_data;

  logic hit, acc, acc_hit, acc_miss, mem_fire, st_same_pend;

  // a same-cycle flush or store to the requested word turns a hit into a miss
  assign hit      = lk_hit && !flush && !(st_valid && st_addr == req_addr);
  assign mem_req_valid = (state == ST_IDLE) && req_valid && !hit;
  assign mem_req_addr  = req_addr;
  assign req_ready = ((state == ST_IDLE) && (hit || mem_req_ready)) ||
                     ((state == ST_HIT) && rsp_ready && hit);
  assign acc      = req_valid && req_ready;
  assign acc_hit  = acc && hit;
  assign acc_miss = acc && !hit;

  assign mem_rsp_ready = (state == ST_WAIT) && rsp_ready;
  assign mem_fire      = mem_rsp_valid && mem_rsp_ready;
  assign st_same_pend  = st_valid && (st_addr == pend_addr);

  assign rsp_valid = (state == ST_HIT) || ((state == ST_WAIT) && mem_rsp_valid);
  assign rsp_data  = (state == ST_HIT) ? hold_data : mem_rsp_data;
  assign rsp_hit   = (state == ST_HIT);

  assign fill_en   = mem_fire && !kill_q && !st_same_pend && !flush;
  assign fill_addr = pend_addr;
  assign fill_data = mem_rsp_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      pend_addr <= '0;
      kill_q    <= 1'b0;
      hold_data <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (acc_hit) begin
            state     <= ST_HIT;
            hold_data <= buf_data;
          end else if (acc_miss) begin
            state     <= ST_WAIT;
            pend_addr <= req_addr;
            kill_q    <= 1'b0;
          end
        end
        ST_HIT: begin
          if (acc_hit) hold_data <= buf_data;
          else if (rsp_ready) state <= ST_IDLE;
        end
        ST_WAIT: begin
          if (st_same_pend) kill_q <= 1'b1;
          if (mem_fire) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_hit)))
    else $error("response changed under back-pressure");

  p_memreq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)))
    else $error("memory request dropped before acceptance");

  p_hit_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |=> (rsp_valid && rsp_hit && !mem_rsp_ready))
    else $error("accepted hit not answered next cycle");

  p_miss_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_miss |=> (!rsp_hit && !req_ready))
    else $error("miss did not wait for memory");
endmodule

// File: rtl/instr_loop_buf.sv
module instr_loop_buf #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 48,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_hit,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [DATA_W-1:0] mem_rsp_data,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic              lk_hit;
  logic [DATA_W-1:0] buf_data;
  logic              fill_en;
  logic [ADDR_W-1:0] fill_addr;
  logic [DATA_W-1:0] fill_data;

  lbuf_tag_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (flush),
    .lk_idx   (req_addr[IDX_W-1:0]),
    .lk_tag   (req_addr[ADDR_W-1:IDX_W]),
    .lk_hit   (lk_hit),
    .fill_en  (fill_en),
    .fill_idx (fill_addr[IDX_W-1:0]),
    .fill_tag (fill_addr[ADDR_W-1:IDX_W]),
    .inv_en   (st_valid),
    .inv_idx  (st_addr[IDX_W-1:0]),
    .inv_tag  (st_addr[ADDR_W-1:IDX_W])
  );

  lbuf_data_array #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .wr_en   (fill_en),
    .wr_idx  (fill_addr[IDX_W-1:0]),
    .wr_data (fill_data),
    .rd_idx  (req_addr[IDX_W-1:0]),
    .rd_data (buf_data)
  );

  lbuf_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_data      (rsp_data),
    .rsp_hit       (rsp_hit),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .mem_rsp_data  (mem_rsp_data),
    .st_valid      (st_valid),
    .st_addr       (st_addr),
    .lk_hit        (lk_hit),
    .buf_data      (buf_data),
    .fill_en       (fill_en),
    .fill_addr     (fill_addr),
    .fill_data     (fill_data)
  );
endmodule

// File: tb/sim_instr_loop_buf.sv
module sim_instr_loop_buf;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [16:0] req_addr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [47:0] rsp_data;
  logic        rsp_hit;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [16:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [47:0] mem_rsp_data = '0;
  logic        st_valid = 1'b0;
  logic [16:0] st_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_loop_buf u0 (.*);

  typedef struct {
    logic        hit;
    logic [47:0] data;
    logic [16:0] addr;
  } exp_t;

  int n_chk = 0, n_bad = 0, cyc = 0, hit_cnt = 0;
  int ver [int];
  bit          ref_v [32];
  logic [11:0] ref_t [32];
  exp_t        eq [$];
  bit rnd_mode = 0, acc_flag = 0, hit_prev = 0, last_hit = 0;
  bit waiting = 0, kill = 0, mpend = 0, mshow = 0;
  logic [16:0] paddr = '0, maddr = '0;
  int mdelay = 0, mlat = 0, first_acc = 0, last_acc = 0;

  function automatic int getver(input logic [16:0] a);
    return ver.exists(int'(a)) ? ver[int'(a)] : 0;
  endfunction

  function automatic logic [47:0] mem_word(input logic [16:0] a, input int v);
    logic [7:0] vb = v[7:0];
    return {vb ^ 8'h5C, a, ~a, vb[5:0]};
  endfunction

  function automatic logic [16:0] rnd_addr();
    logic [11:0] tg;
    case ($urandom % 4)
      0: tg = 12'h000;
      1: tg = 12'h001;
      2: tg = 12'h002;
      default: tg = 12'hABC;
    endcase
    return {tg, 5'($urandom % 32)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // one clock: drive memory side, settle, score handshakes, update models
  task automatic tick();
    exp_t e;
    bit   fillok;
    logic [16:0] faddr;
    if (rnd_mode) begin
      rsp_ready     = ($urandom % 4) != 0;
      mem_req_ready = ($urandom % 3) != 0;
      st_valid      = ($urandom % 8) == 0;
      st_addr       = rnd_addr();
      flush         = ($urandom % 150) == 0;
    end
    if (mpend && !mshow) begin
      if (mdelay == 0) begin
        mshow = 1;
        mem_rsp_data = mem_word(maddr, getver(maddr));
      end else mdelay--;
    end
    mem_rsp_valid = mshow;
    #1;
    acc_flag = 0;
    fillok = 0;
    faddr = paddr;
    if (hit_prev) check(rsp_valid && rsp_hit, "R2 hit answered next cycle", {rsp_valid, rsp_hit}, 2'b11);
    hit_prev = 0;
    if (mshow) check(rsp_valid && !rsp_hit, "R3 memory word forwarded same cycle", {rsp_valid, rsp_hit}, 2'b10);
    if (waiting && st_valid && st_addr == paddr) kill = 1;
    if (rsp_valid && rsp_ready) begin
      if (eq.size() == 0) begin
        check(0, "R10 unexpected response", 1, 0);
      end else begin
        e = eq.pop_front();
        check(rsp_hit == e.hit, "R2 hit flag", rsp_hit, e.hit);
        if (e.hit) check(rsp_data == e.data, "R2 hit data", rsp_data, e.data);
        else check(rsp_data == mem_word(e.addr, getver(e.addr)) || rsp_data == mem_rsp_data,
                   "R3 miss data", rsp_data, mem_rsp_data);
        last_hit = rsp_hit;
        if (rsp_hit) hit_cnt++;
        if (!e.hit) begin
          fillok = !kill && !flush;
          waiting = 0;
          mpend = 0;
          mshow = 0;
        end
      end
    end
    if (req_valid && req_ready) begin
      acc_flag = 1;
      last_acc = cyc;
      e.addr = req_addr;
      e.hit  = ref_v[req_addr[4:0]] && ref_t[req_addr[4:0]] == req_addr[16:5] &&
               !flush && !(st_valid && st_addr == req_addr);
      e.data = mem_word(req_addr, getver(req_addr));
      if (e.hit) begin
        check(!mem_req_valid, "R2 no memory request on hit", mem_req_valid, 0);
        hit_prev = 1;
      end else begin
        check(mem_req_valid && mem_req_addr == req_addr, "R3 memory request address",
              mem_req_addr, req_addr);
        waiting = 1;
        kill = 0;
        paddr = req_addr;
      end
      eq.push_back(e);
    end
    if (mem_req_valid && mem_req_ready) begin
      mpend = 1;
      maddr = mem_req_addr;
      mdelay = rnd_mode ? int'($urandom % 4) : mlat;
    end
    for (int i = 0; i < 32; i++) begin
      if (flush) ref_v[i] = 0;
      else if (fillok && i == int'(faddr[4:0])) begin
        ref_v[i] = 1;
        ref_t[i] = faddr[16:5];
      end else if (st_valid && i == int'(st_addr[4:0]) && ref_t[i] == st_addr[16:5]) ref_v[i] = 0;
    end
    if (st_valid) ver[int'(st_addr)] = getver(st_addr) + 1;
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  task automatic drain();
    req_valid = 0;
    while (eq.size() != 0) tick();
    tick();
  endtask

  task automatic fetch1(input logic [16:0] a);
    req_addr = a;
    req_valid = 1;
    do tick(); while (!acc_flag);
    req_valid = 0;
    drain();
  endtask

  task automatic expect_hit(input logic [16:0] a, input bit exp, input string req);
    fetch1(a);
    check(last_hit == exp, req, last_hit, exp);
  endtask

  task automatic do_flush();
    flush = 1;
    tick();
    flush = 0;
  endtask

  task automatic store1(input logic [16:0] a);
    st_valid = 1;
    st_addr = a;
    tick();
    st_valid = 0;
  endtask

  task automatic stream(input logic [16:0] base, input int n);
    for (int k = 0; k < n; k++) begin
      req_addr = base + 17'(k);
      req_valid = 1;
      do tick(); while (!acc_flag);
      if (k == 0) first_acc = last_acc;
    end
    drain();
  endtask

  task automatic loop_test(input int len, input int exp_hits, input string req);
    do_flush();
    stream(17'h00400, len);
    hit_cnt = 0;
    stream(17'h00400, len);
    check(hit_cnt == exp_hits, req, hit_cnt, exp_hits);
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd7331);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    check(!rsp_valid && !mem_req_valid && req_ready, "R1 reset outputs",
          {rsp_valid, mem_req_valid, req_ready}, 3'b001);
    expect_hit(17'h00123, 0, "R1 first fetch after reset misses");
    expect_hit(17'h00123, 1, "R4 refetch hits");
    expect_hit(17'h00163, 0, "R5 same index other tag misses");
    expect_hit(17'h00123, 0, "R5 replaced address misses");
    expect_hit(17'h00123, 1, "R4 refill hits");
    store1(17'h00123);
    expect_hit(17'h00123, 0, "R8 store invalidates entry");
    store1(17'h00143);
    expect_hit(17'h00123, 1, "R8 store with other tag has no effect");
    req_addr = 17'h00123; req_valid = 1; st_valid = 1; st_addr = 17'h00123;
    tick();
    st_valid = 0;
    drain();
    check(last_hit == 0, "R9 same-cycle store forces miss", last_hit, 0);
    expect_hit(17'h00123, 1, "R4 entry after forced miss");
    req_addr = 17'h00123; req_valid = 1; flush = 1;
    tick();
    flush = 0;
    drain();
    check(last_hit == 0, "R9 same-cycle flush forces miss", last_hit, 0);
    mlat = 2;
    req_addr = 17'h00055; req_valid = 1;
    tick();
    req_valid = 0;
    store1(17'h00055);
    drain();
    mlat = 0;
    expect_hit(17'h00055, 0, "R9 store during outstanding miss blocks fill");
    expect_hit(17'h00055, 1, "R4 later fill kept");
    do_flush();
    expect_hit(17'h00055, 0, "R1 flush empties buffer");
    // back-pressure on a hit response
    fetch1(17'h00055);
    rsp_ready = 0; req_addr = 17'h00055; req_valid = 1;
    tick();
    req_valid = 0;
    for (int k = 0; k < 3; k++) begin
      #1;
      check(rsp_valid && rsp_data == mem_word(17'h00055, getver(17'h00055)),
            "R10 held response stable", rsp_data, mem_word(17'h00055, getver(17'h00055)));
      tick();
    end
    rsp_ready = 1;
    drain();
    loop_test(32, 32, "R6 32-word loop second pass all hits");
    check(last_acc - first_acc == 31, "R10 hits accepted one per cycle", last_acc - first_acc, 31);
    loop_test(20, 20, "R6 20-word loop second pass all hits");
    loop_test(40, 24, "R7 40-word loop hit count");
    loop_test(48, 16, "R7 48-word loop hit count");
    loop_test(64, 0, "R7 64-word loop no hits");
    // random traffic with stores and flushes
    rnd_mode = 1;
    for (int k = 0; k < 4000; k++) begin
      if (!req_valid || acc_flag) begin
        req_valid = ($urandom % 3) != 0;
        req_addr = rnd_addr();
      end
      tick();
    end
    rnd_mode = 0;
    st_valid = 0; flush = 0; rsp_ready = 1; mem_req_ready = 1;
    drain();
    check(eq.size() == 0, "R10 all random requests answered", eq.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule